// File: doc/BRIEF.md
# Three-Lamp Cycling Sequencer

This block is a small clocked state machine that lights exactly one of three lamps (green, yellow, red) at a time. The sequence advances by one lamp per clock edge. A single command input decides whether the machine leaves red. While the command stays high the lamps rotate green, yellow, red without pause. When it is low the machine rests on red. Once a rotation has begun it always runs on to red, whatever the command does in the meantime.

The state is two bits wide. Three codes are used: red is 00, green is 01 and yellow is 10. The fourth code, 11, is never reached in normal operation. If it is entered, it shows yellow for one cycle and then falls back to red. A synchronous test preset loads 11 so that this recovery path can be exercised. The two state bits are brought out on a port for observation.

The state and the lamps are registered together on the same edge, so the lamps always match the state bits.

Top module: `lamp_cycler`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is 00 and only `lamp_red` is lit.
- R2: From state 00, with `go` high and neither `rst` nor `preset` high, the next state is 01 and only `lamp_grn` is lit.
- R3: From state 01, the next state is 10 with only `lamp_yel` lit, whatever the value of `go` (when `rst` and `preset` are low).
- R4: From state 10, the next state is 00 with only `lamp_red` lit, whatever the value of `go` (when `rst` and `preset` are low).
- R5: From state 00, with `go` low, the state stays 00 and `lamp_red` stays lit.
- R6: From state 11, the next state is 00 whatever the value of `go` (when `rst` and `preset` are low).
- R7: With `preset` high and `rst` low at a rising edge, the next state is 11 and only `lamp_yel` is lit.
- R8: When `rst` and `preset` are high together, reset wins and the next state is 00.
- R9: In every cycle after reset, exactly one lamp is lit. `lamp_red` is lit exactly when the state is 00, `lamp_yel` exactly when state bit 1 is set, and `lamp_grn` exactly when the state is 01.
- R10: With `go` held high from red, the lamps repeat green, yellow, red with a period of three clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to red |
| go | input | 1 | Command that lets the machine leave red |
| preset | input | 1 | Synchronous test load of the unused state code 11 |
| lamp_grn | output | 1 | Green lamp, registered |
| lamp_yel | output | 1 | Yellow lamp, registered |
| lamp_red | output | 1 | Red lamp, registered |
| state_q | output | 2 | Raw state bits (bit 1, bit 0) |

## Verification
The bench focuses on the corner cases where a faulty design would show a different lamp.

- Command drops mid-rotation. If `go` fell while green or yellow was lit and the design gated every transition on `go`, it would freeze or skip straight to red.
- Stuck or wrongly decoded state 11. A design that left 11 in place would stay yellow. One that decoded 11 as green would break the one-lamp rule.
- Reset and preset together. A design with the wrong priority would land in 11 instead of red.
- Randomized mix. Commands, presets and occasional resets are driven at random and compared each cycle against a model built from the transition rules. This catches a design that keys the departure from red on anything other than `go`.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int unsigned ST_W = 2;
  localparam int unsigned LAMP_N = 3;

  typedef enum logic [ST_W-1:0] {
    ST_RED   = 2'b00,
    ST_GRN   = 2'b01,
    ST_YEL   = 2'b10,
    ST_TRANS = 2'b11
  } lc_state_e;

  typedef struct packed {
    logic grn;
    logic yel;
    logic red;
  } lc_lamps_t;
endpackage

// File: rtl/lc_next.sv
module lc_next
  import lc_pkg::*;
(
  input  logic            rst,
  input  logic            go,
  input  logic            preset,
  input  logic [ST_W-1:0] cur,
  output logic [ST_W-1:0] nxt
);
  always_comb begin
    if (rst) begin
      nxt = ST_RED;
    end else if (preset) begin
      nxt = ST_TRANS;
    end else begin
      nxt[0] = go & ~cur[1] & ~cur[0];
      nxt[1] = ~cur[1] & cur[0];
    end
  end
endmodule

// File: rtl/lc_lamp_dec.sv
module lc_lamp_dec
  import lc_pkg::*;
(
  input  logic [ST_W-1:0] st,
  output lc_lamps_t       lamps
);
  logic red_w;
  logic yel_w;

  always_comb begin
    red_w     = ~(st[1] | st[0]);
    yel_w     = st[1];
    lamps.red = red_w;
    lamps.yel = yel_w;
    lamps.grn = ~(red_w | yel_w);
  end
endmodule

// File: rtl/lamp_cycler.sv
module lamp_cycler
  import lc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            preset,
  output logic            lamp_grn,
  output logic            lamp_yel,
  output logic            lamp_red,
  output logic [ST_W-1:0] state_q
);
  logic [ST_W-1:0] st_q;
  logic [ST_W-1:0] st_d;
  lc_lamps_t       lamps_d;
  lc_lamps_t       lamps_q;

  lc_next u_next (
    .rst    (rst),
    .go     (go),
    .preset (preset),
    .cur    (st_q),
    .nxt    (st_d)
  );

  lc_lamp_dec u_dec (
    .st    (st_d),
    .lamps (lamps_d)
  );

  always_ff @(posedge clk) begin
    st_q    <= st_d;
    lamps_q <= lamps_d;
  end

  assign state_q  = st_q;
  assign lamp_grn = lamps_q.grn;
  assign lamp_yel = lamps_q.yel;
  assign lamp_red = lamps_q.red;
endmodule

// File: rtl/lc_checker.sv
module lc_checker
  import lc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            go,
  input logic            preset,
  input logic            lamp_grn,
  input logic            lamp_yel,
  input logic            lamp_red,
  input logic [ST_W-1:0] state_q
);
  AST_RESET_RED: assert property (@(posedge clk) rst |=> (state_q == 2'b00 && lamp_red)); // R1
  AST_RESET_OVER_PRESET: assert property (@(posedge clk) (rst && preset) |=> state_q == 2'b00); // R8
  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (rst)
    preset |=> (state_q == 2'b11 && lamp_yel)); // R7
  AST_DEPART_RED: assert property (@(posedge clk) disable iff (rst || preset)
    (state_q == 2'b00 && go) |=> state_q == 2'b01); // R2
  AST_GRN_TO_YEL: assert property (@(posedge clk) disable iff (rst || preset)
    state_q == 2'b01 |=> state_q == 2'b10); // R3
  AST_YEL_TO_RED: assert property (@(posedge clk) disable iff (rst || preset)
    state_q == 2'b10 |=> state_q == 2'b00); // R4
  AST_PARK_RED: assert property (@(posedge clk) disable iff (rst || preset)
    (state_q == 2'b00 && !go) |=> state_q == 2'b00); // R5
  AST_TRANS_RECOVER: assert property (@(posedge clk) disable iff (rst || preset)
    state_q == 2'b11 |=> state_q == 2'b00); // R6
  AST_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
    $countones({lamp_grn, lamp_yel, lamp_red}) == 1); // R9
  AST_RED_MAP: assert property (@(posedge clk) disable iff (rst)
    lamp_red == (state_q == 2'b00)); // R9
endmodule

bind lamp_cycler lc_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .go       (go),
  .preset   (preset),
  .lamp_grn (lamp_grn),
  .lamp_yel (lamp_yel),
  .lamp_red (lamp_red),
  .state_q  (state_q)
);

// File: tb/sim_lamp_cycler.sv
module sim_lamp_cycler;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic go = 1'b0;
  logic preset = 1'b0;
  logic lamp_grn, lamp_yel, lamp_red;
  logic [1:0] state_q;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [1:0] exp_st = 2'b00;

  lamp_cycler u0 (
    .clk(clk), .rst(rst), .go(go), .preset(preset),
    .lamp_grn(lamp_grn), .lamp_yel(lamp_yel), .lamp_red(lamp_red),
    .state_q(state_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [1:0] ref_next(logic r, logic p, logic c, logic [1:0] s);
    if (r) return 2'b00;
    if (p) return 2'b11;
    case (s)
      2'b00: return c ? 2'b01 : 2'b00;
      2'b01: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  // expected lamps {grn,yel,red}
  function automatic logic [2:0] ref_lamps(logic [1:0] s);
    case (s)
      2'b00: return 3'b001;
      2'b01: return 3'b100;
      default: return 3'b010;
    endcase
  endfunction

  function automatic string req_of(logic r, logic p, logic c, logic [1:0] s);
    if (r && p) return "R8";
    if (r) return "R1";
    if (p) return "R7";
    case (s)
      2'b00: return c ? "R2" : "R5";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, logic [4:0] act, logic [4:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got st/lamps=%b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  task automatic step(logic r, logic p, logic c, string tag);
    string req;
    @(negedge clk);
    rst = r; preset = p; go = c;
    req = (tag == "") ? req_of(r, p, c, exp_st) : tag;
    @(posedge clk);
    exp_st = ref_next(r, p, c, exp_st);
    #1;
    chk(req, {state_q, lamp_grn, lamp_yel, lamp_red}, {exp_st, ref_lamps(exp_st)});
    if (!r) begin
      n_chk++;
      if ($countones({lamp_grn, lamp_yel, lamp_red}) != 1) begin
        n_fail++;
        $display("FAIL R9: lamps=%b expected one-hot", {lamp_grn, lamp_yel, lamp_red});
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    step(1, 0, 1, "R1");
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R5");
    step(0, 0, 0, "R5");
    // one-cycle command pulse, then dropped mid-rotation
    step(0, 0, 1, "R2");
    step(0, 0, 0, "R3");
    step(0, 0, 0, "R4");
    step(0, 0, 0, "R5");
    // command held high: period three (R10)
    for (int i = 0; i < 9; i++) step(0, 0, 1, "R10");
    // yellow with command high still goes to red
    step(0, 0, 1, "R2");
    step(0, 0, 1, "R3");
    step(0, 0, 1, "R4");
    // preset and transient recovery
    step(0, 1, 0, "R7");
    step(0, 0, 1, "R6");
    step(0, 1, 1, "R7");
    step(0, 0, 0, "R6");
    step(1, 1, 1, "R8");
    step(0, 0, 0, "R5");
    // randomized mix
    for (int i = 0; i < 2000; i++) begin
      logic rr, pp, cc;
      rr = ($urandom % 50) == 0;
      pp = ($urandom % 16) == 0;
      cc = $urandom % 2;
      step(rr, pp, cc, "");
    end
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYC);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule